// File: doc/BRIEF.md
# Two-Dimensional Product Code Encoder

This block turns a serial stream of information bits into a serial stream holding a systematic two-dimensional product codeword. Two 3-bit selectors pick the constituent code for the row direction (x) and for the column direction (y). Each selector chooses either an extended Hamming code or a single-parity code. Every information row is encoded with the x code. Every column, including the row-parity columns, is encoded with the y code, so the bottom-right corner carries parity computed on parity.

Coded bits leave one per clock, row by row and left to right. Information rows go out as they arrive. The column-parity rows follow, produced from one running column-encoder state per coded column. A pulse on the encode enable while idle captures both selectors and starts a block. The block pulls an information bit only at information positions (`din_ready` high, bit taken when `din_vld` is also high), and it walks through parity positions without input.

Top module: `pc_prod_enc`

## Requirements
- R1: Information bits appear unchanged at coded positions with row < k_y and column < k_x, in arrival order, filled row by row from left to right; the coded array leaves row by row, left to right.
- R2: Each of the first k_y coded rows is a codeword of the x code. The first emitted bit is the highest-degree coefficient. The bits after the information part are the remainder of m(x)·x^r modulo the generator, most significant first. The last bit of the row is the XOR of all the other bits in the row.
- R3: Every coded column, including the columns that hold row parity, is a codeword of the y code with the same bit ordering as R2, taken from top to bottom.
- R4: Selector encoding: bit 2 = 0 selects extended Hamming with n = 8 << s[1:0] and r = s[1:0] + 3, where k = n − 1 − r. The generators are x^3+x+1, x^4+x+1, x^5+x^2+1 and x^6+x+1 for s[1:0] = 0..3. Bit 2 = 1 selects parity only with n = 8 << s[1:0] and k = n − 1.
- R5: A running block emits one coded bit per clock, except at information positions where `din_vld` is low. A block emits exactly n_x·n_y valid bits.
- R6: When `enc_en` is sampled high by an idle block at clock edge 0 and information is available, the first valid output appears after clock edge 4, for every code type.
- R7: `blk_first` is high only together with the first coded bit of a block, and `blk_last` only together with its last bit.
- R8: `x_sel` and `y_sel` are captured when a block starts. Changes to them during the block do not affect its output.
- R9: `din_ready` is high only at information positions of a running block. `din_vld` has no effect while `din_ready` is low, and `enc_en` has no effect while a block is in progress.
- R10: While reset is low and after it, before any block starts, `dout_vld`, `blk_first`, `blk_last` and `din_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_en | input | 1 | Starts a block when the block is idle |
| x_sel | input | 3 | Row constituent code selector |
| y_sel | input | 3 | Column constituent code selector |
| din_vld | input | 1 | Information bit present on `din` |
| din | input | 1 | Information bit |
| din_ready | output | 1 | Current coded position takes an information bit |
| dout | output | 1 | Coded bit |
| dout_vld | output | 1 | `dout` holds a coded bit |
| blk_first | output | 1 | First coded bit of a block |
| blk_last | output | 1 | Last coded bit of a block |

## Verification
The bench uses the single default build. Its maximum column count of 64 and state width of 6 cover all 64 selector pairs, including the full 64×64 array and the lopsided pairs that mix Hamming and parity-only codes. Several pairs are run, both directed and drawn from a fixed-seed random source. Some runs stall the input at information positions, toggle the selectors and `enc_en` mid-block, and offer junk bits at parity positions. Each emitted bit is compared with an array the bench builds by polynomial remainder arithmetic.

// File: rtl/pc_pkg.sv
// Shared constants, the per-code state type and the code-geometry helpers.
// Assumes selector bit 2 picks parity-only and bits 1:0 pick the size.
package pc_pkg;
    localparam int SELW = 3;                 // selector width
    localparam int RMAX = 6;                 // largest Hamming remainder
    localparam int NMAX = 8 << 3;            // largest code length
    localparam int NW   = $clog2(NMAX + 1);  // width of a length count
    localparam int IW   = $clog2(NMAX);      // width of a position index
    localparam int RIW  = $clog2(RMAX);      // width of a remainder index
    localparam int LAT  = 4;                 // enable-to-output clocks

    typedef struct packed {
        logic            par;
        logic [RMAX-1:0] rem;
    } cst_t;

    function automatic logic [NW-1:0] code_n(input logic [SELW-1:0] s);
        return NW'(8) << s[1:0];
    endfunction

    function automatic logic [NW-1:0] code_r(input logic [SELW-1:0] s);
        return s[2] ? '0 : (NW'(s[1:0]) + NW'(3));
    endfunction

    function automatic logic [NW-1:0] code_k(input logic [SELW-1:0] s);
        return code_n(s) - NW'(1) - code_r(s);
    endfunction

    function automatic logic [RMAX-1:0] gen_low(input logic [SELW-1:0] s);
        if (s[2])             return '0;
        else if (s[1:0] == 2) return RMAX'(5);
        else                  return RMAX'(3);
    endfunction

    function automatic logic [RMAX-1:0] rem_mask(input logic [SELW-1:0] s);
        return (RMAX'(1) << code_r(s)) - RMAX'(1);
    endfunction

    // Top bit of the remainder, i.e. the next Hamming parity bit to leave.
    function automatic logic cw_msb(input cst_t st, input logic [SELW-1:0] s);
        logic [NW-1:0] i;
        i = code_r(s) - NW'(1);
        if (s[2]) return 1'b0;
        return st.rem[i[RIW-1:0]];
    endfunction

    // Feed one emitted bit into the divider and the overall parity.
    function automatic cst_t cw_step(input cst_t st, input logic b, input logic [SELW-1:0] s);
        cst_t nx;
        logic fb;
        fb = b ^ cw_msb(st, s);
        nx.rem = ((st.rem << 1) ^ ({RMAX{fb}} & gen_low(s))) & rem_mask(s);
        nx.par = st.par ^ b;
        return nx;
    endfunction
endpackage

// File: rtl/pc_ctrl.sv
// Sequencer: captures the selectors, waits out the start latency, then walks
// the coded array one position per advance. Assumes one block at a time.
module pc_ctrl
    import pc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enc_en,
    input  logic [SELW-1:0] x_sel,
    input  logic [SELW-1:0] y_sel,
    input  logic            din_vld,
    output logic [SELW-1:0] xs,
    output logic [SELW-1:0] ys,
    output logic            busy,
    output logic            run,
    output logic            adv,
    output logic [IW-1:0]   col,
    output logic            in_rows,
    output logic            in_cols,
    output logic            col_last,
    output logic            row_last,
    output logic            at_first
);
    typedef enum logic [1:0] {S_IDLE, S_ARM, S_RUN} st_e;
    localparam int CW = $clog2(LAT);

    st_e             st;
    logic [CW-1:0]   arm_cnt;
    logic [IW-1:0]   row;

    assign busy     = (st != S_IDLE);
    assign run      = (st == S_RUN);
    assign in_rows  = NW'(row) < code_k(ys);
    assign in_cols  = NW'(col) < code_k(xs);
    assign col_last = NW'(col) == code_n(xs) - NW'(1);
    assign row_last = NW'(row) == code_n(ys) - NW'(1);
    assign at_first = (row == '0) && (col == '0);
    // Information positions wait for data; parity positions never do.
    assign adv      = run && (!(in_rows && in_cols) || din_vld);

    // Block state, selector capture and position counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            arm_cnt <= '0;
            row     <= '0;
            col     <= '0;
            xs      <= '0;
            ys      <= '0;
        end else begin
            case (st)
                S_IDLE: if (enc_en) begin
                    xs      <= x_sel;
                    ys      <= y_sel;
                    arm_cnt <= '0;
                    st      <= S_ARM;
                end
                S_ARM: begin
                    arm_cnt <= arm_cnt + CW'(1);
                    if (arm_cnt == CW'(LAT - 2)) st <= S_RUN;
                end
                default: if (adv) begin
                    if (col_last) begin
                        col <= '0;
                        if (row_last) begin
                            row <= '0;
                            st  <= S_IDLE;
                        end else begin
                            row <= row + IW'(1);
                        end
                    end else begin
                        col <= col + IW'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/pc_cw_enc.sv
// Constituent encoder for one code word: passes information bits, then the
// Hamming remainder most significant first, then the overall parity.
// Assumes the caller marks information and final positions.
module pc_cw_enc
    import pc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] sel,
    input  logic            adv,
    input  logic            is_info,
    input  logic            is_last,
    input  logic            din,
    output logic            bit_out
);
    cst_t st;

    assign bit_out = is_info ? din : (is_last ? st.par : cw_msb(st, sel));

    // Update the divider with each emitted bit; clear after the final one.
    always_ff @(posedge clk) begin
        if (!rst_n)       st <= '0;
        else if (adv)     st <= is_last ? '0 : cw_step(st, bit_out, sel);
    end
endmodule

// File: rtl/pc_col_bank.sv
// Bank of per-column encoder states for the y code. Each column is updated
// with the bit emitted in it; the last coded row clears every state.
module pc_col_bank
    import pc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] sel,
    input  logic            adv,
    input  logic [IW-1:0]   idx,
    input  logic            in_rows,
    input  logic            row_last,
    input  logic            row_bit,
    output logic            bit_out
);
    cst_t st [NMAX];
    cst_t cur;

    assign cur     = st[idx];
    assign bit_out = in_rows ? row_bit : (row_last ? cur.par : cw_msb(cur, sel));

    for (genvar g = 0; g < NMAX; g++) begin : g_col
        // Column g state, touched only when its column is emitted.
        always_ff @(posedge clk) begin
            if (!rst_n)
                st[g] <= '0;
            else if (adv && (idx == IW'(g)))
                st[g] <= row_last ? '0 : cw_step(st[g], bit_out, sel);
        end
    end
endmodule

// File: rtl/pc_prod_enc.sv
// Top: product code encoder. Rows use a constituent encoder, columns use the
// per-column bank; the coded bit and its flags are registered once.
module pc_prod_enc
    import pc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enc_en,
    input  logic [SELW-1:0] x_sel,
    input  logic [SELW-1:0] y_sel,
    input  logic            din_vld,
    input  logic            din,
    output logic            din_ready,
    output logic            dout,
    output logic            dout_vld,
    output logic            blk_first,
    output logic            blk_last
);
    logic [SELW-1:0] xs, ys;
    logic            busy, run, adv, in_rows, in_cols, col_last, row_last, at_first;
    logic [IW-1:0]   col;
    logic            row_bit, cw_bit;

    pc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .enc_en(enc_en), .x_sel(x_sel), .y_sel(y_sel),
        .din_vld(din_vld), .xs(xs), .ys(ys), .busy(busy), .run(run), .adv(adv),
        .col(col), .in_rows(in_rows), .in_cols(in_cols), .col_last(col_last),
        .row_last(row_last), .at_first(at_first)
    );

    pc_cw_enc u_row (
        .clk(clk), .rst_n(rst_n), .sel(xs), .adv(adv && in_rows),
        .is_info(in_cols), .is_last(col_last), .din(din), .bit_out(row_bit)
    );

    pc_col_bank u_cols (
        .clk(clk), .rst_n(rst_n), .sel(ys), .adv(adv), .idx(col),
        .in_rows(in_rows), .row_last(row_last), .row_bit(row_bit), .bit_out(cw_bit)
    );

    assign din_ready = run && in_rows && in_cols;

    // Output register: one coded bit and its position flags per advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout      <= 1'b0;
            dout_vld  <= 1'b0;
            blk_first <= 1'b0;
            blk_last  <= 1'b0;
        end else begin
            dout      <= adv ? cw_bit : 1'b0;
            dout_vld  <= adv;
            blk_first <= adv && at_first;
            blk_last  <= adv && row_last && col_last;
        end
    end
endmodule

// File: rtl/pc_prod_enc_chk.sv
// Checker for pc_prod_enc: port-level and sequencing properties.
module pc_prod_enc_chk
    import pc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            din_vld,
    input logic            din_ready,
    input logic            dout_vld,
    input logic            blk_first,
    input logic            blk_last,
    input logic            busy,
    input logic [SELW-1:0] xs,
    input logic [SELW-1:0] ys
);
    // R7
    flag_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_first || blk_last) |-> dout_vld);
    // R7
    first_last_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(blk_first && blk_last));
    // R8
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(xs) && $stable(ys)));
    // R5
    take_emits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (din_ready && din_vld) |=> dout_vld);
    // R9
    ready_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        din_ready |-> busy);
endmodule

bind pc_prod_enc pc_prod_enc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .din_vld(din_vld), .din_ready(din_ready),
    .dout_vld(dout_vld), .blk_first(blk_first), .blk_last(blk_last),
    .busy(busy), .xs(xs), .ys(ys)
);

// File: tb/pc_prod_enc_tb.sv
`timescale 1ns/1ps
module pc_prod_enc_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_en = 1'b0;
    logic [2:0] x_sel = '0, y_sel = '0;
    logic       din_vld = 1'b0, din = 1'b0;
    logic       din_ready, dout, dout_vld, blk_first, blk_last;
    int         checks = 0, failures = 0;
    logic       data_bits [4096];
    logic       exp_bits  [4096];

    always #2.5 clk = ~clk;

    pc_prod_enc u_dut (
        .clk(clk), .rst_n(rst_n), .enc_en(enc_en), .x_sel(x_sel), .y_sel(y_sel),
        .din_vld(din_vld), .din(din), .din_ready(din_ready), .dout(dout),
        .dout_vld(dout_vld), .blk_first(blk_first), .blk_last(blk_last)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // x^e modulo the generator of remainder width r (R4 generators).
    function automatic logic [6:0] xpow_mod(input int e, input int r);
        logic [6:0] p = 7'd1;
        logic [6:0] g = (r == 5) ? 7'd5 : 7'd3;
        for (int i = 0; i < e; i++) begin
            p = p << 1;
            if (p[r]) p = p ^ (7'd1 << r) ^ g;
        end
        return p;
    endfunction

    // Reference codeword: d[0] is the first-emitted information bit.
    function automatic logic [63:0] ref_cw(input logic [63:0] d, input logic [2:0] s);
        int n = 8 << s[1:0];
        int r = s[2] ? 0 : s[1:0] + 3;
        int k = n - 1 - r;
        logic [63:0] cw = '0;
        logic [6:0] rem = '0;
        logic p = 1'b0;
        for (int i = 0; i < k; i++) begin
            cw[i] = d[i];
            if (d[i]) rem = rem ^ xpow_mod(n - 2 - i, r);
        end
        for (int j = 0; j < r; j++) cw[k + j] = rem[r - 1 - j];
        for (int i = 0; i < n - 1; i++) p = p ^ cw[i];
        cw[n - 1] = p;
        return cw;
    endfunction

    task automatic build_expected(input logic [2:0] xs, input logic [2:0] ys);
        int nx = 8 << xs[1:0], ny = 8 << ys[1:0];
        int kx = xs[2] ? nx - 1 : nx - 4 - xs[1:0];
        int ky = ys[2] ? ny - 1 : ny - 4 - ys[1:0];
        logic [63:0] v, cw;
        for (int r = 0; r < ky; r++) begin
            v = '0;
            for (int c = 0; c < kx; c++) v[c] = data_bits[r * kx + c];
            cw = ref_cw(v, xs);
            for (int c = 0; c < nx; c++) exp_bits[r * nx + c] = cw[c];
        end
        for (int c = 0; c < nx; c++) begin
            v = '0;
            for (int r = 0; r < ky; r++) v[r] = exp_bits[r * nx + c];
            cw = ref_cw(v, ys);
            for (int r = ky; r < ny; r++) exp_bits[r * nx + c] = cw[r];
        end
    endtask

    // One block: stall = percent of stalled information slots, poke = disturb
    // selectors, enc_en and din_vld during the block.
    task automatic run_block(input logic [2:0] xs, input logic [2:0] ys, input int stall, input bit poke);
        int nx = 8 << xs[1:0], ny = 8 << ys[1:0];
        int total = nx * ny;
        int got = 0, di = 0, cyc = 0;
        string lbl;
        for (int i = 0; i < 4096; i++) data_bits[i] = 1'($urandom);
        build_expected(xs, ys);
        x_sel = xs; y_sel = ys; enc_en = 1'b1;
        @(posedge clk); #1;
        enc_en = 1'b0;
        while (got < total && cyc < 20000) begin
            @(posedge clk); #1;
            cyc++;
            if (dout_vld) begin
                if (got == 0) check("R6 first-valid clock", cyc, 4);
                lbl = ((got / nx) < (ys[2] ? ny - 1 : ny - 4 - ys[1:0]))
                      ? (((got % nx) < (xs[2] ? nx - 1 : nx - 4 - xs[1:0])) ? "R1 info bit" : "R2 row parity")
                      : "R3 column parity";
                check(lbl, dout, exp_bits[got]);
                check("R7 flags", {blk_first, blk_last}, {got == 0, got == total - 1});
                got++;
            end
            if (poke) begin
                x_sel = 3'($urandom); y_sel = 3'($urandom);
                enc_en = ($urandom % 8) == 0;
            end
            if (din_ready) begin
                if (di == 0 || ($urandom % 100) >= stall) begin
                    din_vld = 1'b1; din = data_bits[di]; di++;
                end else begin
                    din_vld = 1'b0; din = 1'($urandom);
                end
            end else begin
                din_vld = poke ? 1'($urandom) : 1'b0;
                din = 1'($urandom);
            end
        end
        enc_en = 1'b0; din_vld = 1'b0;
        check("R5 bit count", got, total);
        if (cyc >= 20000) check("R5 block hung", 1, 0);
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1;
            check("R9 idle after block", {dout_vld, din_ready}, 2'b00);
        end
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset outputs", {dout_vld, blk_first, blk_last, din_ready}, 4'b0000);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R10 idle after reset", {dout_vld, blk_first, blk_last, din_ready}, 4'b0000);
        run_block(3'd0, 3'd0, 0, 1'b0);   // R4 smallest Hamming pair
        run_block(3'd3, 3'd3, 0, 1'b0);   // R4 largest Hamming pair
        run_block(3'd7, 3'd7, 0, 1'b0);   // R4 largest parity-only pair
        run_block(3'd4, 3'd1, 30, 1'b1);  // R8 R9 disturbed block
        run_block(3'd2, 3'd6, 20, 1'b1);  // R8 R9 disturbed block
        run_block(3'd1, 3'd5, 0, 1'b0);
        run_block(3'd6, 3'd2, 10, 1'b0);
        for (int i = 0; i < 3; i++)
            run_block(3'($urandom), 3'($urandom), 25, 1'($urandom));
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule